// File: doc/BRIEF.md
# Multi-Round Interrupt Priority Arbiter

This block picks, among a bank of interrupt sources, the pending and enabled source with the largest 8-bit priority number. It passes that winner to the CPU as an interrupt request. Each source has a pending flag, set by a one-cycle request pulse, plus its own enable bit and priority number. The arbiter takes a snapshot of the eligible sources and then narrows them down over several rounds. Each round compares one slice of the priority number, starting from the most significant bits. Two fields of a small control word set the arbitration latency: the number of rounds (1 to 4) and the clocks per round (1 or 2).

When an arbitration completes, its winner's priority appears in the published pending-priority field. This field is cleared at the start of every arbitration. The winner is held for the CPU, and the interrupt line is raised only while the global interrupt enable is set. When the CPU acknowledges, the hardware does three things in that cycle. It clears the winner's pending flag, saves the global enable and clears it, and restarts arbitration. A return event puts the saved enable back. Software can also turn the enable on or off with explicit commands.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, the control word reads all zeros: round select 0, clock select 0, global enable 0 and pending priority 0. The interrupt line is low.
- R2: A completed arbitration yields the largest priority number among sources that are pending, enabled and have a non-zero priority. A priority of 0 is never a valid request, and when no source qualifies the result is 0.
- R3: Control bits [1:0] choose the number of rounds: 00 gives 4, 01 gives 3, 10 gives 2 and 11 gives 1. Bit [2] chooses the clocks per round: 0 gives 2 and 1 gives 1. After an accepted acknowledge at edge A, the new result appears at edge A+1+rounds×clocks.
- R4: The pending-priority field (read bits [15:8]) is 0 from the start of an arbitration until that arbitration completes. While the field is non-zero, it equals the priority offered to the CPU.
- R5: The interrupt line is high only while a winner is held and the global enable (read bit [3]) is 1.
- R6: An accepted acknowledge (acknowledge while the interrupt line is high) saves the global enable and clears it. It also clears the winner's pending flag and restarts arbitration. In the same cycle it takes precedence over an enable command.
- R7: A return event with no accepted acknowledge in the same cycle restores the saved global enable.
- R8: The enable command sets the global enable and the disable command clears it. When both arrive in the same cycle, disable wins.
- R9: Only control bits [2:0] are writable. Bits [31:16] and [7:4] always read 0, writes to them are ignored, and writable bits change only on a write.
- R10: A request raised while an arbitration is running is not considered until the next arbitration.
- R11: A request pulse from the winning source in the same cycle as an accepted acknowledge leaves that source's pending flag set.
- R12: A pending source whose enable bit is 0 does not take part in arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | One-cycle request pulses that set each source's pending flag |
| src_en | input | NUM_SRC | Per-source enable |
| src_prio | input | NUM_SRC*8 | Priority numbers; source i uses bits [8i+7:8i] |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word: [1:0] rounds, [2] clocks, [3] global enable, [15:8] pending priority |
| ie_set | input | 1 | Enable command for the global enable |
| ie_clr | input | 1 | Disable command for the global enable |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_prio | output | 8 | Priority of the held winner, 0 when none |
| cpu_ack | input | 1 | CPU acknowledge |
| cpu_rfe | input | 1 | Return-from-exception event |
| ie | output | 1 | Current global enable |

## Verification
An acknowledge can land in the same cycle as other events, and two of these collisions are provoked here. In one, the winning source pulses a new request in the acknowledge cycle. In the other, an enable command is issued in that same cycle. The bench drives both together against a held winner, while the line is high. It then judges the outcome at the ports: the global enable must read 0 right after that edge, and once the enable is restored and an arbitration has run, the same priority must be offered again, which shows the pending flag survived.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int PRIO_W = 8;
  localparam int CFG_W  = 32;

  typedef logic [PRIO_W-1:0] prio_t;

  // Bits compared in round k when the arbitration uses nrounds rounds:
  // equal slices from the top, the last slice takes what remains.
  function automatic prio_t slice_mask(input logic [2:0] nrounds, input logic [1:0] k);
    int w;
    int hi;
    int lo;
    prio_t m;
    w  = (PRIO_W + int'(nrounds) - 1) / ((nrounds == 3'd0) ? 1 : int'(nrounds));
    hi = PRIO_W - 1 - int'(k) * w;
    lo = hi - w + 1;
    if (lo < 0) lo = 0;
    m = '0;
    for (int b = 0; b < PRIO_W; b++)
      if (b >= lo && b <= hi) m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/srn_bank.sv
module srn_bank import arb_pkg::*; #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      req_pulse,
  input  logic [N-1:0]      src_en,
  input  logic [N*PRIO_W-1:0] src_prio,
  input  logic              clr_valid,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic [N-1:0]      cand
);
  logic [N-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (req_pulse[i])
          pend[i] <= 1'b1;
        else if (clr_valid && clr_idx == IDX_W'(i))
          pend[i] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cand
    assign cand[i] = pend[i] & src_en[i] & (src_prio[i*PRIO_W +: PRIO_W] != '0);
  end
endmodule

// File: rtl/slice_elim.sv
module slice_elim import arb_pkg::*; #(
  parameter int N = 8
) (
  input  logic [N-1:0]        alive,
  input  logic [N*PRIO_W-1:0] src_prio,
  input  prio_t               mask,
  output logic [N-1:0]        keep
);
  prio_t best;

  always_comb begin
    best = '0;
    for (int i = 0; i < N; i++)
      if (alive[i] && ((src_prio[i*PRIO_W +: PRIO_W] & mask) > best))
        best = src_prio[i*PRIO_W +: PRIO_W] & mask;
    for (int i = 0; i < N; i++)
      keep[i] = alive[i] && ((src_prio[i*PRIO_W +: PRIO_W] & mask) == best);
  end
endmodule

// File: rtl/ie_unit.sv
module ie_unit (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic rfe,
  input  logic en_cmd,
  input  logic dis_cmd,
  output logic ie,
  output logic saved
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ie    <= 1'b0;
      saved <= 1'b0;
    end else if (take) begin
      saved <= ie;
      ie    <= 1'b0;
    end else if (rfe) begin
      ie <= saved;
    end else if (dis_cmd) begin
      ie <= 1'b0;
    end else if (en_cmd) begin
      ie <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter import arb_pkg::*; #(
  parameter int NUM_SRC = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        src_req,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic                      cfg_we,
  input  logic [CFG_W-1:0]          cfg_wdata,
  output logic [CFG_W-1:0]          cfg_rdata,
  input  logic                      ie_set,
  input  logic                      ie_clr,
  output logic                      cpu_irq,
  output logic [PRIO_W-1:0]         cpu_prio,
  input  logic                      cpu_ack,
  input  logic                      cpu_rfe,
  output logic                      ie
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [1:0]         cfg_rsel;
  logic               cfg_one;
  logic [2:0]         lat_rounds;
  logic               lat_one;
  logic               start_q;
  logic [1:0]         rnd_q;
  logic               sub_q;
  logic [NUM_SRC-1:0] alive;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] keep;
  prio_t              pipn;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  prio_t              win_prio;
  logic               ie_saved;
  logic               take;
  logic               last_sub;
  logic               last_rnd;
  prio_t              cur_mask;
  logic               found;
  logic [IDX_W-1:0]   w_idx;
  prio_t              w_prio;
  logic               unused_wdata;

  assign take     = cpu_ack & cpu_irq;
  assign last_sub = lat_one | sub_q;
  assign last_rnd = ({1'b0, rnd_q} == (lat_rounds - 3'd1));
  assign cur_mask = slice_mask(lat_rounds, rnd_q);
  assign unused_wdata = ^cfg_wdata[CFG_W-1:3];

  srn_bank #(.N(NUM_SRC), .IDX_W(IDX_W)) bank_i (
    .clk       (clk),
    .rst       (rst),
    .req_pulse (src_req),
    .src_en    (src_en),
    .src_prio  (src_prio),
    .clr_valid (take),
    .clr_idx   (win_idx),
    .cand      (cand)
  );

  slice_elim #(.N(NUM_SRC)) elim_i (
    .alive    (alive),
    .src_prio (src_prio),
    .mask     (cur_mask),
    .keep     (keep)
  );

  ie_unit ie_i (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .rfe     (cpu_rfe),
    .en_cmd  (ie_set),
    .dis_cmd (ie_clr),
    .ie      (ie),
    .saved   (ie_saved)
  );

  // Lowest index among the survivors of the final round.
  always_comb begin
    found  = 1'b0;
    w_idx  = '0;
    w_prio = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (keep[i]) begin
        found  = 1'b1;
        w_idx  = IDX_W'(i);
        w_prio = src_prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rsel   <= 2'b00;
      cfg_one    <= 1'b0;
      lat_rounds <= 3'd4;
      lat_one    <= 1'b0;
      start_q    <= 1'b1;
      rnd_q      <= 2'd0;
      sub_q      <= 1'b0;
      alive      <= '0;
      pipn       <= '0;
      win_valid  <= 1'b0;
      win_idx    <= '0;
      win_prio   <= '0;
    end else begin
      if (cfg_we) begin
        cfg_rsel <= cfg_wdata[1:0];
        cfg_one  <= cfg_wdata[2];
      end
      if (take) begin
        start_q   <= 1'b1;
        pipn      <= '0;
        win_valid <= 1'b0;
      end else if (start_q) begin
        start_q    <= 1'b0;
        pipn       <= '0;
        alive      <= cand;
        rnd_q      <= 2'd0;
        sub_q      <= 1'b0;
        lat_rounds <= 3'd4 - {1'b0, cfg_rsel};
        lat_one    <= cfg_one;
      end else if (!last_sub) begin
        sub_q <= 1'b1;
      end else begin
        sub_q <= 1'b0;
        alive <= keep;
        if (last_rnd) begin
          start_q   <= 1'b1;
          pipn      <= found ? w_prio : '0;
          win_valid <= found;
          win_idx   <= w_idx;
          win_prio  <= found ? w_prio : '0;
        end else begin
          rnd_q <= rnd_q + 2'd1;
        end
      end
    end
  end

  assign cpu_irq   = win_valid & ie;
  assign cpu_prio  = win_prio & {PRIO_W{win_valid}};
  assign cfg_rdata = {16'b0, pipn, 4'b0, ie, cfg_one, cfg_rsel};
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker import arb_pkg::*; (
  input logic             clk,
  input logic             rst,
  input logic             cpu_ack,
  input logic             cpu_rfe,
  input logic             cpu_irq,
  input logic [PRIO_W-1:0] cpu_prio,
  input logic             ie,
  input logic             saved_ie,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_rdata
);
  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> ie);

  assert_irq_prio_valid_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (cpu_prio != '0));

  assert_take_clears_ie_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && cpu_irq) |=> !ie);

  assert_rfe_restores_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_rfe && !(cpu_ack && cpu_irq)) |=> (ie == $past(saved_ie)));

  assert_pipn_matches_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[15:8] != 8'h00) |-> (cpu_prio == cfg_rdata[15:8]));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[31:16] == 16'h0) && (cfg_rdata[7:4] == 4'h0));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_rdata[2:0]));
endmodule

bind irq_prio_arbiter irq_arb_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .cpu_ack   (cpu_ack),
  .cpu_rfe   (cpu_rfe),
  .cpu_irq   (cpu_irq),
  .cpu_prio  (cpu_prio),
  .ie        (ie),
  .saved_ie  (ie_saved),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata)
);

// File: tb/irq_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb_top;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_req = '0;
  logic [N-1:0]  src_en = '0;
  logic [N*8-1:0] src_prio = '0;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          ie_set = 1'b0;
  logic          ie_clr = 1'b0;
  logic          cpu_irq;
  logic [7:0]    cpu_prio;
  logic          cpu_ack = 1'b0;
  logic          cpu_rfe = 1'b0;
  logic          ie;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  irq_prio_arbiter #(.NUM_SRC(N)) dut_i (
    .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en), .src_prio(src_prio),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ie_set(ie_set), .ie_clr(ie_clr), .cpu_irq(cpu_irq), .cpu_prio(cpu_prio),
    .cpu_ack(cpu_ack), .cpu_rfe(cpu_rfe), .ie(ie)
  );

  // {round select, one clock, enables, priorities node7..node0, expected}
  localparam logic [82:0] VECS [0:5] = '{
    {2'd0, 1'b0, 8'hFF, 64'h8070605040302010, 8'h80},
    {2'd3, 1'b1, 8'h7F, 64'h8070605040302010, 8'h70},
    {2'd1, 1'b0, 8'hFF, 64'hC407413FC6C7C500, 8'hC7},
    {2'd2, 1'b1, 8'hFF, 64'h0000000000000000, 8'h00},
    {2'd0, 1'b1, 8'h0A, 64'hFFFFFFFF12FF11FF, 8'h12},
    {2'd1, 1'b1, 8'hFF, 64'h81807F0102FE00FD, 8'hFE}
  };

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    cfg_wdata = d; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    src_req = m;
    step();
    src_req = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic ack_now();
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
  endtask

  task automatic rfe_now();
    cpu_rfe = 1'b1;
    step();
    cpu_rfe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1 cfg_rdata", cfg_rdata, 32'h0);
    check("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);

    // R9: only [2:0] writable, reserved read 0
    wr_cfg(32'hFFFF_FFFF);
    check("R9 reserved", cfg_rdata & 32'hFFFF_00F7, 32'h0000_0007);
    wr_cfg(32'h0);
    check("R9 clear", cfg_rdata & 32'hFFFF_00F7, 32'h0);

    // R8: enable and disable commands
    ie_set = 1'b1; step(); ie_set = 1'b0;
    check("R8 set", {31'b0, cfg_rdata[3]}, 32'h1);
    ie_set = 1'b1; ie_clr = 1'b1; step(); ie_set = 1'b0; ie_clr = 1'b0;
    check("R8 both", {31'b0, ie}, 32'h0);

    // R2/R3/R12: vector table
    for (int v = 0; v < 6; v++) begin
      wr_cfg({29'b0, VECS[v][81], VECS[v][82:81] == 2'b00 ? 2'b00 : VECS[v][82:81]});
      wr_cfg({29'b0, VECS[v][80], VECS[v][82:81]});
      src_en   = VECS[v][79:72];
      src_prio = VECS[v][71:8];
      pulse_req('1);
      step(20);
      check($sformatf("R2 vec%0d", v), {24'b0, cpu_prio}, {24'b0, VECS[v][7:0]});
    end

    // R3/R4/R5/R6/R7: latency after acknowledge, 4 rounds x 2 clocks
    do_reset();
    src_prio = '0;
    src_prio[2*8 +: 8] = 8'h50;
    src_prio[5*8 +: 8] = 8'h30;
    src_en = 8'b0010_0100;
    pulse_req(8'b0010_0100);
    ie_set = 1'b1; step(); ie_set = 1'b0;
    step(20);
    check("R5 irq high", {31'b0, cpu_irq}, 32'h1);
    check("R2 winner", {24'b0, cpu_prio}, 32'h50);
    ack_now();
    check("R6 ie cleared", {31'b0, ie}, 32'h0);
    check("R5 irq low", {31'b0, cpu_irq}, 32'h0);
    step(8);
    check("R4 field zero", {24'b0, cfg_rdata[15:8]}, 32'h0);
    step(1);
    check("R3 result 4x2", {24'b0, cfg_rdata[15:8]}, 32'h30);
    check("R6 next winner", {24'b0, cpu_prio}, 32'h30);
    rfe_now();
    check("R7 restored", {31'b0, ie}, 32'h1);
    check("R5 irq again", {31'b0, cpu_irq}, 32'h1);

    // R3: 1 round x 1 clock
    wr_cfg(32'h7);
    pulse_req(8'b0000_0100);
    step(20);
    check("R2 node2 back", {24'b0, cpu_prio}, 32'h50);
    ack_now();
    step(1);
    check("R3 field zero 1x1", {24'b0, cfg_rdata[15:8]}, 32'h0);
    step(1);
    check("R3 result 1x1", {24'b0, cfg_rdata[15:8]}, 32'h30);
    rfe_now();

    // R10: request raised mid arbitration waits for the next one
    wr_cfg(32'h0);
    step(20);
    check("R10 pre winner", {24'b0, cpu_prio}, 32'h30);
    ack_now();
    step(2);
    src_req = 8'b0000_0100;
    step();
    src_req = '0;
    step(6);
    check("R10 not in current", {24'b0, cpu_prio}, 32'h0);
    step(10);
    check("R10 in next", {24'b0, cpu_prio}, 32'h50);
    rfe_now();

    // R11/R6: ack, new request from the winner and enable command together
    step(2);
    check("R11 pre irq", {31'b0, cpu_irq}, 32'h1);
    cpu_ack = 1'b1; src_req = 8'b0000_0100; ie_set = 1'b1;
    step();
    cpu_ack = 1'b0; src_req = '0; ie_set = 1'b0;
    check("R6 ack beats enable", {31'b0, ie}, 32'h0);
    rfe_now();
    step(20);
    check("R11 pending kept", {24'b0, cpu_prio}, 32'h50);

    // R12: disabled source ignored
    src_en[2] = 1'b0;
    step(20);
    check("R12 disabled prio", {24'b0, cpu_prio}, 32'h0);
    check("R12 disabled irq", {31'b0, cpu_irq}, 32'h0);

    summary();
  end
endmodule